// File: doc/BRIEF.md
# Two-Stage SPI Bit-Clock Divider

This block derives the serial bit clock of an SPI master from the module clock. The division runs in two cascaded stages. A linear stage divides by any whole number from 1 to 16. A power-of-two stage then divides its output by 1, 2, 4 and so on up to 32768. The product of the two ratios sets the number of module clocks between consecutive SCLK edges.

Alongside the SCLK level, the block gives the serial engine a one-cycle tick on every SCLK edge. The tick comes with exactly one of two strobes, either "sample" or "shift". The clock-phase input decides which strobe belongs to the leading edge of each bit period and which belongs to the trailing edge. While no burst is running, the counters are held cleared and SCLK rests at the level set by the clock-polarity input. Because the counters start from zero, the first edge of every burst has full width.

Top module: `spi_clkdiv2`

## Requirements
- R1: After reset, with `run_i` low, `sclk_o` equals `cpol_i` and `edge_tick_o`, `sample_stb_o` and `shift_stb_o` are all 0.
- R2: `rate_sel_i[7:4]` is the linear field P and `rate_sel_i[3:0]` is the power-of-two field Q. The SCLK half period is D = (P+1) * 2^Q module clocks.
- R3: With `run_i` sampled high on N consecutive rising edges from an idle start, `edge_tick_o` is high in the cycle after the N-th edge exactly when N is a non-zero multiple of D. The first edge of a burst therefore comes a full D cycles after the start.
- R4: While running, `sclk_o` equals `cpol_i` XOR (the parity of the number of edge ticks so far). SCLK therefore changes only together with an edge tick.
- R5: With `cpha_i`=0, odd-numbered (leading) edges carry `sample_stb_o` and even-numbered (trailing) edges carry `shift_stb_o`. With `cpha_i`=1 the roles are swapped.
- R6: Every edge tick carries exactly one of the two strobes, and neither strobe is ever high without an edge tick.
- R7: One clock after `run_i` is sampled low, the counters and the phase are cleared. `sclk_o` then follows `cpol_i` and no tick occurs. A new burst starts again with a full-width first edge.
- R8: The extreme settings work. P=0,Q=0 gives an edge every cycle. Q=15 gives a first edge after 32768 cycles and none before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Burst active; low clears and holds the divider |
| rate_sel_i | input | 8 | [7:4] linear divide field, [3:0] power-of-two field |
| cpol_i | input | 1 | SCLK idle level |
| cpha_i | input | 1 | Selects which edge samples and which shifts |
| sclk_o | output | 1 | Serial bit clock |
| edge_tick_o | output | 1 | One-cycle pulse per SCLK edge |
| sample_stb_o | output | 1 | Sample strobe, coincident with an edge tick |
| shift_stb_o | output | 1 | Shift strobe, coincident with an edge tick |

## Verification
The bench aims at the off-by-one points of both stages. A linear stage that divides by P instead of P+1, or a power-of-two stage whose terminal count is wrong, moves the tick away from the exact multiples of D. The divide-by-one setting and the largest post-divide setting are run in full, so a skipped or early first edge shows at once.

A burst is cut mid-period and then restarted. Counters that failed to clear would give a short first edge. SCLK is also checked against a polarity change while idle. Both clock-phase settings are run, which exposes swapped or doubled sample and shift strobes.

// File: rtl/spi_clkdiv2_pkg.sv
package spi_clkdiv2_pkg;
  localparam int unsigned LIN_W_DEF = 4;
  localparam int unsigned EXP_W_DEF = 4;

  // SCLK level relative to the polarity setting
  typedef enum logic {
    LVL_REST  = 1'b0,
    LVL_ACTIVE = 1'b1
  } sclk_lvl_e;
endpackage

// File: rtl/spi_lin_div.sv
module spi_lin_div #(
  parameter int unsigned LIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [LIN_W-1:0] lin_sel_i,
  output logic             lin_tick_o
);
  logic [LIN_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  always_comb begin
    wrap  = run_i && (cnt_q >= lin_sel_i);
    cnt_d = cnt_q;
    if (!run_i)    cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign lin_tick_o = wrap;

  AST_LIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/spi_exp_div.sv
module spi_exp_div #(
  parameter int unsigned EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             lin_tick_i,
  input  logic [EXP_W-1:0] exp_sel_i,
  output logic             edge_o
);
  localparam int unsigned CNT_W = (1 << EXP_W) - 1;
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;
  logic             wrap;

  always_comb begin
    limit = ALL_ONES >> (CNT_W - int'(exp_sel_i));
    wrap  = run_i && lin_tick_i && (cnt_q >= limit);
    cnt_d = cnt_q;
    if (!run_i)          cnt_d = '0;
    else if (wrap)       cnt_d = '0;
    else if (lin_tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign edge_o = wrap;

  AST_EDGE_NEEDS_LIN: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |-> lin_tick_i); // R2
endmodule

// File: rtl/spi_edge_phase.sv
module spi_edge_phase
  import spi_clkdiv2_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run_i,
  input  logic      edge_i,
  input  logic      cpha_i,
  output sclk_lvl_e lvl_o,
  output logic      tick_o,
  output logic      sample_o,
  output logic      shift_o
);
  sclk_lvl_e lvl_q, lvl_d;
  logic      tick_q, tick_d;
  logic      smp_q, smp_d;
  logic      shf_q, shf_d;
  logic      leading;

  always_comb begin
    lvl_d   = lvl_q;
    tick_d  = 1'b0;
    smp_d   = 1'b0;
    shf_d   = 1'b0;
    leading = (lvl_q == LVL_REST);
    if (!run_i) begin
      lvl_d = LVL_REST;
    end else if (edge_i) begin
      lvl_d  = leading ? LVL_ACTIVE : LVL_REST;
      tick_d = 1'b1;
      smp_d  = leading ^ cpha_i;
      shf_d  = ~(leading ^ cpha_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= LVL_REST;
      tick_q <= 1'b0;
      smp_q  <= 1'b0;
      shf_q  <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      tick_q <= tick_d;
      smp_q  <= smp_d;
      shf_q  <= shf_d;
    end
  end

  assign lvl_o    = lvl_q;
  assign tick_o   = tick_q;
  assign sample_o = smp_q;
  assign shift_o  = shf_q;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> $countones({sample_o, shift_o}) == 1); // R6
  AST_STROBE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o || shift_o) |-> tick_o); // R6
  AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !tick_o); // R7
  AST_LVL_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && !tick_o) |-> $stable(lvl_o)); // R4
endmodule

// File: rtl/spi_clkdiv2.sv
module spi_clkdiv2
  import spi_clkdiv2_pkg::*;
#(
  parameter int unsigned LIN_W = LIN_W_DEF,
  parameter int unsigned EXP_W = EXP_W_DEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run_i,
  input  logic [LIN_W+EXP_W-1:0] rate_sel_i,
  input  logic                   cpol_i,
  input  logic                   cpha_i,
  output logic                   sclk_o,
  output logic                   edge_tick_o,
  output logic                   sample_stb_o,
  output logic                   shift_stb_o
);
  localparam int unsigned SEL_W = LIN_W + EXP_W;

  logic      lin_tick;
  logic      div_edge;
  sclk_lvl_e lvl;

  spi_lin_div #(.LIN_W(LIN_W)) u_lin (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_i),
    .lin_sel_i  (rate_sel_i[SEL_W-1:EXP_W]),
    .lin_tick_o (lin_tick)
  );

  spi_exp_div #(.EXP_W(EXP_W)) u_exp (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_i),
    .lin_tick_i (lin_tick),
    .exp_sel_i  (rate_sel_i[EXP_W-1:0]),
    .edge_o     (div_edge)
  );

  spi_edge_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run_i),
    .edge_i   (div_edge),
    .cpha_i   (cpha_i),
    .lvl_o    (lvl),
    .tick_o   (edge_tick_o),
    .sample_o (sample_stb_o),
    .shift_o  (shift_stb_o)
  );

  assign sclk_o = cpol_i ^ (lvl == LVL_ACTIVE);

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !$past(run_i)) |-> (sclk_o == cpol_i)); // R4
endmodule

// File: tb/spi_clkdiv2_tb.sv
module spi_clkdiv2_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       run;
  logic [7:0] rate_sel;
  logic       cpol, cpha;
  logic       sclk, tick, smp, shf;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  bit          done   = 1'b0;

  always #5 clk = ~clk;

  spi_clkdiv2 u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (run),
    .rate_sel_i   (rate_sel),
    .cpol_i       (cpol),
    .cpha_i       (cpha),
    .sclk_o       (sclk),
    .edge_tick_o  (tick),
    .sample_stb_o (smp),
    .shift_stb_o  (shf)
  );

  // {P, Q, cpol, cpha, cycles}
  localparam int NV = 6;
  localparam logic [25:0] VEC [NV] = '{
    {4'd0,  4'd0, 1'b0, 1'b0, 16'd12},
    {4'd2,  4'd0, 1'b1, 1'b0, 16'd30},
    {4'd0,  4'd2, 1'b0, 1'b1, 16'd40},
    {4'd3,  4'd1, 1'b1, 1'b1, 16'd64},
    {4'd15, 4'd0, 1'b0, 1'b1, 16'd80},
    {4'd1,  4'd3, 1'b1, 1'b0, 16'd96}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One burst from idle; checks every cycle against the model of R2..R6
  task automatic burst(input logic [3:0] p, input logic [3:0] q,
                       input logic pol, input logic pha, input int ncyc,
                       input bit drop_at_end);
    int d;
    d = (int'(p) + 1) * (1 << q);
    @(negedge clk);
    rate_sel = {p, q};
    cpol = pol;
    cpha = pha;
    run  = 1'b1;
    for (int n = 1; n <= ncyc; n++) begin
      int  k;
      bit  et, lead;
      @(negedge clk);
      et   = (n % d) == 0;
      k    = n / d;
      lead = k[0];
      chk("R3 tick", int'(tick), int'(et));
      chk("R4 sclk", int'(sclk), int'(pol ^ k[0]));
      chk("R5 sample", int'(smp), int'(et && (lead ^ pha)));
      chk("R5 shift", int'(shf), int'(et && !(lead ^ pha)));
    end
    if (drop_at_end) begin
      run = 1'b0;
      @(negedge clk);
      chk("R7 idle sclk", int'(sclk), int'(pol));
      chk("R7 idle tick", int'(tick), 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; run = 1'b0; rate_sel = 8'h00; cpol = 1'b1; cpha = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 sclk", int'(sclk), 1);
    chk("R1 tick", int'(tick), 0);
    chk("R1 strobes", int'(smp | shf), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    cpol = 1'b0;
    #1 chk("R1 sclk follows cpol", int'(sclk), 0);

    // R2..R6 table walk
    for (int v = 0; v < NV; v++)
      burst(VEC[v][25:22], VEC[v][21:18], VEC[v][17], VEC[v][16],
            int'(VEC[v][15:0]), 1'b1);

    // R7: cut a burst mid-period, idle, then restart with a full first edge
    burst(4'd3, 4'd1, 1'b0, 1'b0, 13, 1'b0);
    run = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk("R7 cut sclk", int'(sclk), 0);
      chk("R7 cut tick", int'(tick), 0);
    end
    cpol = 1'b1;
    #1 chk("R7 idle polarity", int'(sclk), 1);
    burst(4'd3, 4'd1, 1'b0, 1'b0, 24, 1'b1);

    // R8: largest post-divide, first edge at 32768
    burst(4'd0, 4'd15, 1'b0, 1'b1, 32769, 1'b1);
    // R8: divide-by-one, edge each cycle
    burst(4'd0, 4'd0, 1'b1, 1'b1, 8, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule